// File: doc/BRIEF.md
# Multithread Issue Slot Scheduler

This block decides, once per clock, which of several hardware threads may send an instruction into one shared in-order pipeline. It produces a valid flag and a thread tag. The tag travels with the instruction down every pipeline stage, so that each stage reads and writes the per-thread state of the right thread. When no thread may issue, the block emits a bubble (valid low).

A two-bit policy input selects one of four policies. The policies act as the states of the scheduler, and a change of the input is the transition between them.
- `POL_FIXED` (0) rotates strictly through the threads.
- `POL_TABLE` (1) steps through a software-written table of issue slots.
- `POL_READY` (2) grants the first ready thread in rotating priority order.
- `POL_HALT` (3) issues nothing.

A transition out of `POL_FIXED` clears the rotation pointer. A transition out of `POL_TABLE` clears the slot pointer. The last-granted thread used by `POL_READY` survives every transition.

The slot table has a write port. Each entry is 3 bits wide. An entry value of 0 to 3 names a thread, and a value of 4 to 7 names no thread. Writes land in a staging copy. The staging copy is moved into the active copy only at the start of a table pass, so a single pass never mixes old and new entries.

Top module: `mts_sched`

## Requirements
- R1: With mode 0, the thread tag steps 0,1,2,3,0,... one per cycle. Entering mode 0 from any other mode starts the rotation at thread 0.
- R2: With mode 0, if the thread owning the current cycle has its ready bit low, the block issues a bubble. No other thread takes that cycle, and the rotation still advances.
- R3: With mode 1, the slot pointer starts at slot 0 on entry and advances one slot per cycle, wrapping after slot 7. The block issues the thread named in the current entry when that thread's ready bit is high, and a bubble otherwise.
- R4: A table write made while mode 1 is active takes effect at the next pass through slot 0. A write accepted on the edge that enters slot 0 already applies to that pass. A write made while another mode is active applies from the next cycle.
- R5: A table entry holding a value of 4 or more always yields a bubble, whatever the ready vector.
- R6: After reset, table slot i holds thread i mod 4, and mode 0 issues thread 0 first. The first mode 2 grant after reset searches from thread 0.
- R7: With mode 2, the block grants the first ready thread found after the last granted thread, in increasing order with wrap-around. It issues a bubble when no thread is ready. The last granted thread is kept across mode changes.
- R8: With mode 3, every cycle is a bubble.
- R9: In every mode, a valid issue names a thread whose ready bit is high, and a bubble carries thread tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | 4 | Per-thread ready bits, bit i for thread i |
| mode | input | 2 | Policy: 0 fixed, 1 table, 2 ready-priority, 3 halt |
| wr_en | input | 1 | Slot table write strobe |
| wr_slot | input | 3 | Slot index to write |
| wr_entry | input | 3 | Thread number to store; 4 to 7 mark a dead slot |
| issue_valid | output | 1 | High when a thread issues this cycle |
| issue_tid | output | 2 | Thread tag of the issuing thread, 0 on a bubble |

## Verification
The assertions assume that `mode`, `ready` and the write port are stable around each rising edge. They also assume that the policy seen one cycle earlier is a real driven value, which is why the checks that look back one cycle are held off until one clean cycle after reset. The stimulus changes every input only on the falling edge, and it holds the policy at halt while reset is released. The ready vector is walked through full, partial and empty patterns, and table writes are placed both before the slot-0 boundary and exactly on it.

// File: rtl/mts_pkg.sv
package mts_pkg;
    typedef enum logic [1:0] {
        POL_FIXED = 2'd0,
        POL_TABLE = 2'd1,
        POL_READY = 2'd2,
        POL_HALT  = 2'd3
    } policy_e;
endpackage

// File: rtl/mts_wrap_ctr.sv
module mts_wrap_ctr #(
    parameter int LIMIT = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (step) begin
            count <= (count == LAST) ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/mts_slot_table.sv
module mts_slot_table #(
    parameter int N  = 4,
    parameter int S  = 8,
    parameter int EW = 3,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_slot,
    input  logic [EW-1:0] wr_entry,
    input  logic          commit,
    input  logic [PW-1:0] rd_slot,
    output logic [EW-1:0] rd_entry
);
    logic [EW-1:0] stage_q  [S];
    logic [EW-1:0] stage_d  [S];
    logic [EW-1:0] active_q [S];

    always_comb begin
        stage_d = stage_q;
        if (wr_en) begin
            stage_d[wr_slot] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < S; i++) begin
                stage_q[i]  <= EW'(i % N);
                active_q[i] <= EW'(i % N);
            end
        end else begin
            stage_q <= stage_d;
            if (commit) begin
                active_q <= stage_d;
            end
        end
    end

    assign rd_entry = active_q[rd_slot];
endmodule

// File: rtl/mts_rr_pick.sv
module mts_rr_pick #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] last,
    output logic          gnt_valid,
    output logic [TW-1:0] gnt_id
);
    always_comb begin
        int idx;
        gnt_valid = 1'b0;
        gnt_id    = '0;
        for (int k = N; k >= 1; k--) begin
            idx = (int'(last) + k) % N;
            if (req[idx]) begin
                gnt_valid = 1'b1;
                gnt_id    = TW'(idx);
            end
        end
    end
endmodule

// File: rtl/mts_sched.sv
module mts_sched
    import mts_pkg::*;
#(
    parameter int N = 4,
    parameter int S = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         ready,
    input  logic [1:0]           mode,
    input  logic                 wr_en,
    input  logic [$clog2(S)-1:0] wr_slot,
    input  logic [$clog2(N):0]   wr_entry,
    output logic                 issue_valid,
    output logic [$clog2(N)-1:0] issue_tid
);
    localparam int TW = $clog2(N);
    localparam int EW = TW + 1;
    localparam int PW = $clog2(S);
    localparam logic [PW-1:0] SLOT_LAST = PW'(S - 1);

    policy_e       pol;
    logic [TW-1:0] rot_q;
    logic [PW-1:0] slot_q;
    logic [TW-1:0] last_q;
    logic [EW-1:0] entry;
    logic          entry_ok;
    logic          commit;
    logic          rr_valid;
    logic [TW-1:0] rr_id;

    assign pol = policy_e'(mode);

    mts_wrap_ctr #(.LIMIT(N), .W(TW)) rot_ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(pol != POL_FIXED),
        .step (pol == POL_FIXED),
        .count(rot_q)
    );

    mts_wrap_ctr #(.LIMIT(S), .W(PW)) slot_ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(pol != POL_TABLE),
        .step (pol == POL_TABLE),
        .count(slot_q)
    );

    assign commit = (pol != POL_TABLE) || (slot_q == SLOT_LAST);

    mts_slot_table #(.N(N), .S(S), .EW(EW), .PW(PW)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_entry(wr_entry),
        .commit  (commit),
        .rd_slot (slot_q),
        .rd_entry(entry)
    );

    assign entry_ok = (entry < EW'(N));

    mts_rr_pick #(.N(N), .TW(TW)) pick_i (
        .req      (ready),
        .last     (last_q),
        .gnt_valid(rr_valid),
        .gnt_id   (rr_id)
    );

    // state register: last grant of the ready-priority policy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= TW'(N - 1);
        end else if (pol == POL_READY && rr_valid) begin
            last_q <= rr_id;
        end
    end

    // output process per policy state
    always_comb begin
        issue_valid = 1'b0;
        issue_tid   = '0;
        unique case (pol)
            POL_FIXED: begin
                issue_valid = ready[rot_q];
                issue_tid   = ready[rot_q] ? rot_q : '0;
            end
            POL_TABLE: begin
                if (entry_ok && ready[entry[TW-1:0]]) begin
                    issue_valid = 1'b1;
                    issue_tid   = entry[TW-1:0];
                end
            end
            POL_READY: begin
                issue_valid = rr_valid;
                issue_tid   = rr_id;
            end
            POL_HALT: begin
                issue_valid = 1'b0;
                issue_tid   = '0;
            end
            default: begin
                issue_valid = 1'b0;
                issue_tid   = '0;
            end
        endcase
    end
endmodule

// File: rtl/mts_sched_chk.sv
module mts_sched_chk #(
    parameter int N = 4,
    parameter int S = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         ready,
    input logic [1:0]           mode,
    input logic                 issue_valid,
    input logic [$clog2(N)-1:0] issue_tid,
    input logic [$clog2(S)-1:0] slot_pos
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_valid_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ready[issue_tid]);

    p_bubble_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> issue_tid == '0);

    p_halt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd3 |-> !issue_valid);

    p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && |ready) |-> issue_valid);

    p_fixed_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode == 2'd0 && $past(mode) == 2'd0 && issue_valid && $past(issue_valid))
        |-> int'(issue_tid) == (int'($past(issue_tid)) + 1) % N);

    p_table_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode == 2'd1 && $past(mode) != 2'd1) |-> slot_pos == '0);
endmodule

bind mts_sched mts_sched_chk #(.N(N), .S(S)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .mode       (mode),
    .issue_valid(issue_valid),
    .issue_tid  (issue_tid),
    .slot_pos   (slot_q)
);

// File: tb/mts_sched_tb_top.sv
`timescale 1ns/1ps
module mts_sched_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ready = 4'h0;
    logic [1:0] mode = 2'd3;
    logic       wr_en = 1'b0;
    logic [2:0] wr_slot = 3'd0;
    logic [2:0] wr_entry = 3'd0;
    logic       issue_valid;
    logic [1:0] issue_tid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    bit    qv[$];
    int    qt[$];
    string qtag[$];

    int m_rot = 0, m_slot = 0, m_last = 3;
    int m_stage[8];
    int m_active[8];

    always #2.5 clk = ~clk;

    mts_sched dut_i (
        .clk(clk), .rst_n(rst_n), .ready(ready), .mode(mode),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_entry(wr_entry),
        .issue_valid(issue_valid), .issue_tid(issue_tid)
    );

    task automatic step(input int md, input logic [3:0] rdy, input bit we,
                        input int ws, input int wt, input string tag);
        bit ev;
        int et;
        int e;
        int idx;
        @(negedge clk);
        mode = md[1:0]; ready = rdy; wr_en = we;
        wr_slot = ws[2:0]; wr_entry = wt[2:0];
        ev = 1'b0; et = 0;
        case (md)
            0: begin ev = rdy[m_rot]; et = ev ? m_rot : 0; end
            1: begin
                e = m_active[m_slot];
                ev = (e < 4) && rdy[e];
                et = ev ? e : 0;
            end
            2: begin
                for (int k = 4; k >= 1; k--) begin
                    idx = (m_last + k) % 4;
                    if (rdy[idx]) begin ev = 1'b1; et = idx; end
                end
            end
            default: begin ev = 1'b0; et = 0; end
        endcase
        qv.push_back(ev); qt.push_back(et); qtag.push_back(tag);
        if (we) m_stage[ws] = wt;
        if (md != 1 || m_slot == 7) m_active = m_stage;
        m_rot  = (md == 0) ? (m_rot + 1) % 4 : 0;
        m_slot = (md == 1) ? (m_slot + 1) % 8 : 0;
        if (md == 2 && ev) m_last = et;
    endtask

    task automatic run(input int md, input logic [3:0] rdy, input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) step(md, rdy, 1'b0, 0, 0, tag);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (qv.size() > 0) begin
                bit    ev;
                int    et;
                string tg;
                ev = qv.pop_front(); et = qt.pop_front(); tg = qtag.pop_front();
                n_checks++;
                if (issue_valid !== ev || int'(issue_tid) != et) begin
                    n_fails++;
                    $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                             tg, issue_valid, issue_tid, ev, et);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_stage[i]  = i % 4;
            m_active[i] = i % 4;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        mode = 2'd0; ready = 4'hF;
        #1;
        n_checks++;
        if (issue_valid !== 1'b1 || issue_tid !== 2'd0) begin
            n_fails++;
            $display("FAIL R6 reset: valid=%0b tid=%0d expected valid=1 tid=0",
                     issue_valid, issue_tid);
        end
        mode = 2'd3;
        @(negedge clk);
        rst_n = 1'b1;

        run(0, 4'hF, 8, "R1 rotation");
        run(0, 4'b1011, 8, "R2 owner not ready");
        run(3, 4'hF, 2, "R8 halt");
        run(0, 4'hF, 2, "R1 restart");
        run(1, 4'hF, 8, "R6 default table");
        step(3, 4'hF, 1'b1, 0, 2, "R8 write while halted");
        step(3, 4'hF, 1'b1, 1, 6, "R8 write while halted");
        step(3, 4'hF, 1'b1, 4, 3, "R8 write while halted");
        run(1, 4'hF, 8, "R5 dead slot");
        run(1, 4'hF, 3, "R4 pass before write");
        step(1, 4'hF, 1'b1, 6, 1, "R4 mid-pass write");
        run(1, 4'hF, 3, "R4 old entry kept");
        step(1, 4'hF, 1'b1, 0, 3, "R4 write on wrap edge");
        run(1, 4'hF, 8, "R4 new pass");
        run(1, 4'b0101, 8, "R3 owner not ready");
        run(3, 4'hF, 1, "R8 halt");
        run(2, 4'hF, 6, "R7 all ready");
        run(2, 4'b1010, 4, "R7 sparse ready");
        run(2, 4'b0000, 2, "R7 none ready");
        run(2, 4'b0001, 2, "R7 single ready");
        run(0, 4'hF, 1, "R1 interleaved");
        run(2, 4'hF, 3, "R7 grant kept");
        run(3, 4'h0, 2, "R9 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule